// File: doc/BRIEF.md
# Low-Area Masked DES Substitution Unit

This unit evaluates one DES substitution box on a Boolean-masked operand without a mask-correction table indexed by both data and mask. It receives the masked 6-bit operand, the 6-bit input mask and the 6-bit round subkey. It returns a masked 4-bit result together with the 4-bit output mask that goes with it. Two copies of the ordinary 64-entry substitution table are used. The first copy is indexed by the keyed masked operand, and its output is passed on directly as the masked result. The second copy is indexed by the keyed operand after the mask has been stripped. The output mask is the XOR of the two lookups.

The unit is purely combinational. A round datapath places eight instances side by side, and a parameter picks which of the eight standard DES tables each instance holds. With this structure the unit costs about two plain tables instead of one table of 4096 words. In return, the unmasked keyed operand is present on the net that feeds the second table, and this is accepted.

Top module: `maskedSboxUnit`

## Requirements
- R1: `maskedOut` equals S(`maskedIn` XOR `subKey`). It does not depend on `inMask` in any other way.
- R2: `outMask` equals S(`maskedIn` XOR `subKey`) XOR S(`maskedIn` XOR `inMask` XOR `subKey`).
- R3: For every combination of `maskedIn`, `inMask` and `subKey`, `maskedOut` XOR `outMask` equals S(x XOR `subKey`), where x = `maskedIn` XOR `inMask`.
- R4: When `inMask` is zero, `outMask` is zero and `maskedOut` equals the plain lookup.
- R5: A 6-bit table index selects its entry as follows. Bits 5 (high) and 0 (low) form the 2-bit row, and bits 4..1 form the 4-bit column. The entry number is row*16+column. For example, with table 1, index 6'b100001 returns 15, 6'b011110 returns 7, 6'b000001 returns 0 and 6'b100000 returns 4.
- R6: Parameter `SBOX_ID` (1 to 8) selects the standard DES table of that number. For example, with table 8, index 0 returns 13 and index 63 returns 11.
- R7: The outputs depend only on the current inputs. There is no clock and no state, and a new input settles in the same time step.
- R8: The index of the plain lookup and the index of the masked lookup differ by exactly `inMask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| maskedIn | input | 6 | Operand XORed with the input mask |
| inMask | input | 6 | Input mask |
| subKey | input | 6 | Round subkey slice for this table |
| maskedOut | output | 4 | Substitution result under the output mask |
| outMask | output | 4 | Output mask that goes with `maskedOut` |

## Verification
The bound checker looks at every settled input combination. It checks that the two table indices differ by the input mask and that the outputs recombine to the plain lookup. It also checks that a zero mask gives a zero output mask and that known inputs give known outputs. None of these checks needs a reference table. The values themselves can only be shown by the bench. Those are the row and column mapping, the choice of table by the parameter, and the exhaustive equality with S(x XOR k) over all 2^18 input triples. The bench compares them against tables of its own.

// File: rtl/maskedSboxPkg.sv
package maskedSboxPkg;

  localparam int SBOX_IN_W    = 6;
  localparam int SBOX_OUT_W   = 4;
  localparam int SBOX_ENTRIES = 1 << SBOX_IN_W;
  localparam int SBOX_BITS    = SBOX_ENTRIES * SBOX_OUT_W;
  localparam int SBOX_COUNT   = 8;

  // Tables are packed row by row, with entry 0 in the top nibble.
  function automatic logic [SBOX_BITS-1:0] sboxTable(input int id);
    case (id)
      1: sboxTable = {64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538,
                      64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D};
      2: sboxTable = {64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5,
                      64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9};
      3: sboxTable = {64'hA09E63F51DC7B428, 64'hD70934A6285ECBF1,
                      64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C};
      4: sboxTable = {64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9,
                      64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E};
      5: sboxTable = {64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986,
                      64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453};
      6: sboxTable = {64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38,
                      64'h9EF528C3704A1DB6, 64'h432C95FABE17608D};
      7: sboxTable = {64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86,
                      64'h14BDC37EAF680592, 64'h6BD814A7950FE23C};
      default: sboxTable = {64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92,
                            64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};
    endcase
  endfunction

  // Outer bits make the row, inner bits the column: entry = row*16 + col.
  function automatic logic [SBOX_IN_W-1:0] sboxEntryPos(input logic [SBOX_IN_W-1:0] idx);
    sboxEntryPos = {idx[5], idx[0], idx[4:1]};
  endfunction

endpackage

// File: rtl/sboxLookup.sv
module sboxLookup
  import maskedSboxPkg::*;
#(
  parameter int SBOX_ID = 1
) (
  input  logic [SBOX_IN_W-1:0]  idxIn,
  output logic [SBOX_OUT_W-1:0] valOut
);
  localparam int SEL_ID = (SBOX_ID >= 1 && SBOX_ID <= SBOX_COUNT) ? SBOX_ID : 1;
  localparam logic [SBOX_BITS-1:0] TABLE_BITS = sboxTable(SEL_ID);
  localparam int SHIFT_W = SBOX_IN_W + 2;

  logic [SBOX_IN_W-1:0] entryPos;
  logic [SBOX_IN_W-1:0] revPos;
  logic [SHIFT_W-1:0]   bitBase;

  always_comb begin
    entryPos = sboxEntryPos(idxIn);
    revPos   = ~entryPos;
    bitBase  = {revPos, 2'b00};
    valOut   = TABLE_BITS[bitBase +: SBOX_OUT_W];
  end
endmodule

// File: rtl/maskedSboxCore.sv
module maskedSboxCore
  import maskedSboxPkg::*;
#(
  parameter int SBOX_ID = 1
) (
  input  logic [SBOX_IN_W-1:0]  maskedIn,
  input  logic [SBOX_IN_W-1:0]  inMask,
  input  logic [SBOX_IN_W-1:0]  subKey,
  output logic [SBOX_OUT_W-1:0] maskedOut,
  output logic [SBOX_OUT_W-1:0] outMask,
  output logic [SBOX_IN_W-1:0]  keyedIdx,
  output logic [SBOX_IN_W-1:0]  plainIdx,
  output logic [SBOX_OUT_W-1:0] plainVal
);
  logic [SBOX_OUT_W-1:0] keyedVal;

  // Masked branch: key mixing on the masked operand.
  assign keyedIdx = maskedIn ^ subKey;
  // Plain branch: strip the mask after keying; this net carries x^k.
  assign plainIdx = keyedIdx ^ inMask;

  sboxLookup #(.SBOX_ID(SBOX_ID)) u_maskedTable (
    .idxIn (keyedIdx),
    .valOut(keyedVal)
  );

  sboxLookup #(.SBOX_ID(SBOX_ID)) u_plainTable (
    .idxIn (plainIdx),
    .valOut(plainVal)
  );

  assign maskedOut = keyedVal;
  assign outMask   = keyedVal ^ plainVal;
endmodule

// File: rtl/maskedSboxUnit.sv
module maskedSboxUnit #(
  parameter int SBOX_ID = 1
) (
  input  logic [5:0] maskedIn,
  input  logic [5:0] inMask,
  input  logic [5:0] subKey,
  output logic [3:0] maskedOut,
  output logic [3:0] outMask
);
  logic [5:0] keyedIdx;
  logic [5:0] plainIdx;
  logic [3:0] plainVal;

  maskedSboxCore #(.SBOX_ID(SBOX_ID)) u_core (
    .maskedIn (maskedIn),
    .inMask   (inMask),
    .subKey   (subKey),
    .maskedOut(maskedOut),
    .outMask  (outMask),
    .keyedIdx (keyedIdx),
    .plainIdx (plainIdx),
    .plainVal (plainVal)
  );
endmodule

// File: rtl/maskedSboxChecker.sv
module maskedSboxChecker (
  input logic [5:0] maskedIn,
  input logic [5:0] inMask,
  input logic [5:0] subKey,
  input logic [3:0] maskedOut,
  input logic [3:0] outMask,
  input logic [5:0] keyedIdx,
  input logic [5:0] plainIdx,
  input logic [3:0] plainVal
);
  always_comb begin
    if (!$isunknown({maskedIn, inMask, subKey})) begin
      // R8: the two lookups are indexed exactly one mask apart
      a_r8_index_gap: assert ((keyedIdx ^ plainIdx) == inMask)
        else $error("R8 index gap");
      // R3: outputs recombine to the unmasked lookup
      a_r3_recombine: assert ((maskedOut ^ outMask) == plainVal)
        else $error("R3 recombine");
      // R4: no mask in, no mask out
      a_r4_zero_mask: assert (inMask != 6'd0 || outMask == 4'd0)
        else $error("R4 zero mask");
      // R4: with no mask both tables agree
      a_r4_same_value: assert (inMask != 6'd0 || maskedOut == plainVal)
        else $error("R4 same value");
      // R7: known inputs give known outputs at once
      a_r7_known_out: assert (!$isunknown({maskedOut, outMask}))
        else $error("R7 unknown output");
    end
  end
endmodule

bind maskedSboxUnit maskedSboxChecker u_checker (
  .maskedIn (maskedIn),
  .inMask   (inMask),
  .subKey   (subKey),
  .maskedOut(maskedOut),
  .outMask  (outMask),
  .keyedIdx (keyedIdx),
  .plainIdx (plainIdx),
  .plainVal (plainVal)
);

// File: tb/maskedSboxUnit_bench.sv
module maskedSboxUnit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] maskedIn, inMask, subKey;
  logic [3:0] maskedOut, outMask, maskedOut8, outMask8;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  maskedSboxUnit u_maskedSboxUnit (
    .maskedIn(maskedIn), .inMask(inMask), .subKey(subKey),
    .maskedOut(maskedOut), .outMask(outMask)
  );

  maskedSboxUnit #(.SBOX_ID(8)) u_maskedSboxUnit_s8 (
    .maskedIn(maskedIn), .inMask(inMask), .subKey(subKey),
    .maskedOut(maskedOut8), .outMask(outMask8)
  );

  // Reference tables, rows of 16 values, entry 0 leftmost.
  function automatic logic [3:0] refS(input int id, input logic [5:0] idx);
    logic [255:0] t;
    int pos;
    if (id == 8)
      t = {64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92,
           64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};
    else
      t = {64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538,
           64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D};
    pos = ({30'd0, idx[5], idx[0]} * 16) + int'(idx[4:1]);
    return t[(63 - pos) * 4 +: 4];
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (in=%h m=%h k=%h)", tag, got, exp, maskedIn, inMask, subKey);
    end
  endtask

  task automatic apply(input logic [5:0] a, input logic [5:0] m, input logic [5:0] k);
    maskedIn = a; inMask = m; subKey = k;
    #1;
  endtask

  task automatic checkAll(input int id, input logic [3:0] mo, input logic [3:0] om);
    logic [5:0] x;
    x = maskedIn ^ inMask;
    check("R1", mo, refS(id, maskedIn ^ subKey));
    check("R2", om, refS(id, maskedIn ^ subKey) ^ refS(id, maskedIn ^ inMask ^ subKey));
    check("R3", mo ^ om, refS(id, x ^ subKey));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=%0d exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    maskedIn = '0; inMask = '0; subKey = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    // all-zero inputs: table 1 entry 0 is 14, no mask
    check("R4 zero state maskedOut", maskedOut, 4'hE);
    check("R4 zero state outMask", outMask, 4'h0);

    // R5 row/column mapping corners on table 1 (key and mask zero)
    apply(6'b100001, 6'd0, 6'd0); check("R5 row3 col0", maskedOut, 4'd15);
    apply(6'b011110, 6'd0, 6'd0); check("R5 row0 col15", maskedOut, 4'd7);
    apply(6'b000001, 6'd0, 6'd0); check("R5 row1 col0", maskedOut, 4'd0);
    apply(6'b100000, 6'd0, 6'd0); check("R5 row2 col0", maskedOut, 4'd4);

    // R6 table selection
    apply(6'd0, 6'd0, 6'd0);  check("R6 table8 idx0", maskedOut8, 4'd13);
    apply(6'd63, 6'd0, 6'd0); check("R6 table8 idx63", maskedOut8, 4'd11);

    // R4 zero mask with nonzero key
    apply(6'h2A, 6'd0, 6'h15);
    check("R4 outMask zero", outMask, 4'd0);
    check("R4 plain value", maskedOut, refS(1, 6'h2A ^ 6'h15));

    // R1 mask must not influence the masked branch beyond maskedIn
    apply(6'h11, 6'h3F, 6'h07);
    check("R1 mask-free branch", maskedOut, refS(1, 6'h11 ^ 6'h07));

    // R7 outputs follow a new input without any clock edge
    @(negedge clk);
    apply(6'h05, 6'h09, 6'h30);
    check("R7 same-step settle", maskedOut ^ outMask, refS(1, 6'h05 ^ 6'h09 ^ 6'h30));

    // random mix on both tables
    for (int i = 0; i < 2000; i++) begin
      apply(6'($urandom), 6'($urandom), 6'($urandom));
      checkAll(1, maskedOut, outMask);
      checkAll(8, maskedOut8, outMask8);
    end

    // R3 exhaustive over every x, m, k on table 1
    for (int k = 0; k < 64; k++)
      for (int m = 0; m < 64; m++)
        for (int x = 0; x < 64; x++) begin
          apply(6'(x ^ m), 6'(m), 6'(k));
          check("R3 exhaustive", maskedOut ^ outMask, refS(1, 6'(x ^ k)));
        end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule